// File: doc/BRIEF.md
# Multi-Port Dock Handshake Wrapper with Coordinated Flush

This block wraps a function unit that has several input docks and several output docks. Each dock runs a four-phase request/acknowledge handshake. An input word is one bit wider than the data path, and its top bit marks a flush token. The wrapper decides when a dock is full, empty or draining. It retires finished handshakes one cycle after their final phase is seen.

When every input dock holds a word that has not yet been acknowledged, the flush bits decide what happens. If every pending word is a token, all of the tokens are discarded together. If only some of them are tokens, the ordinary words are discarded and the tokens wait. The docks therefore drain up to a common token before any of them moves on.

The function unit here is a placeholder. It consumes one word from each input dock once all input docks are full and all output docks are empty. It then presents on each output dock the XOR of the input data fields, XORed again with that dock's index.

Top module: `dock_flush_top`

## Requirements
- R1: While `rstN` is low at a rising edge, the following cycle shows every `inAck` bit at 1 and every `outReq` bit at 0.
- R2: An input dock whose effective request is low drops its acknowledge one cycle after the acknowledge is seen high. The effective request is the raw request with the flush bit (word bit DATA_W) clear.
- R3: An output dock whose `outReq` and `outAck` are both high at an edge has `outReq` low in the next cycle.
- R4: When every input dock is full and every output dock is empty at an edge, the next cycle raises all `inAck` bits and all `outReq` bits together. Full means effective request high and `inAck` low. Empty means `outReq` and `outAck` both low. Output dock k then carries flag bit 0 and, in bits DATA_W-1:0, the XOR of all input data fields XOR k.
- R5: When every input dock has a raw request with `inAck` low and every word has its flush bit set, all `inAck` bits are high in the next cycle.
- R6: When every input dock has a raw request with `inAck` low and some, but not all, words carry the flush bit, the next cycle raises `inAck` only on the docks whose word lacks the bit. Flagged docks stay low.
- R7: An acknowledge raised by a flush falls one cycle after the raw request of that dock is seen low.
- R8: No output request rises unless every input dock is full and every output dock is empty at the same edge.
- R9: `outWord` of a dock stays unchanged for as long as its `outReq` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inReq | input | NUM_IN | Raw request per input dock |
| inWord | input | NUM_IN*(DATA_W+1) | Input words; dock i at bits i*(DATA_W+1) and up, top bit is the flush flag |
| inAck | output | NUM_IN | Acknowledge per input dock (normal or flush) |
| outReq | output | NUM_OUT | Request per output dock |
| outWord | output | NUM_OUT*(DATA_W+1) | Output words, same packing, flag bit always 0 |
| outAck | input | NUM_OUT | Acknowledge per output dock |

## Verification
Every result of this block is due exactly one cycle after the rising edge that samples its cause. Acknowledges, requests and output words are all registered, and no input reaches an output through logic alone. The bench drives all inputs at the falling edge and advances its reference model at the rising edge, using the same sampled inputs. At the next falling edge it compares `inAck`, `outReq` and every valid `outWord` against the model. Each compare is tagged with the rule that last set the expected value, so a wrong consume, flush or retire is named where it first shows.

// File: rtl/dock_flush_pkg.sv
`timescale 1ns/1ps
package dock_flush_pkg;

  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic fire;       // consume all inputs, fill all outputs
    logic flushAll;   // every pending word is a token: drop them all
    logic flushSome;  // mixed: drop the non-token words only
  } dock_strobe_t;

endpackage

// File: rtl/dock_flush_ctrl.sv
`timescale 1ns/1ps
module dock_flush_ctrl
  import dock_flush_pkg::*;
#(
  parameter int NUM_IN  = 3,
  parameter int NUM_OUT = 2
) (
  input  logic [NUM_IN-1:0]  inReq,
  input  logic [NUM_IN-1:0]  inFlag,
  input  logic [NUM_IN-1:0]  ackReg,
  input  logic [NUM_IN-1:0]  flushReg,
  input  logic [NUM_OUT-1:0] reqReg,
  input  logic [NUM_OUT-1:0] outAck,
  output dock_strobe_t       strb,
  output logic [NUM_IN-1:0]  inAckDrop,
  output logic [NUM_OUT-1:0] outReqDrop
);

  logic [NUM_IN-1:0]  effReq;
  logic [NUM_IN-1:0]  inFull;
  logic [NUM_IN-1:0]  inPending;
  logic [NUM_OUT-1:0] outEmpty;
  logic [NUM_OUT-1:0] outDraining;

  always_comb begin
    effReq      = inReq & ~inFlag;
    inFull      = effReq & ~ackReg & ~flushReg;
    inPending   = inReq & ~ackReg;
    outEmpty    = ~reqReg & ~outAck;
    outDraining = reqReg & outAck;
  end

  always_comb begin
    inAckDrop      = ~effReq & ackReg;
    outReqDrop     = outDraining;
    strb.fire      = (&inFull) && (&outEmpty);
    strb.flushAll  = (&inPending) && (&inFlag);
    strb.flushSome = (&inPending) && (|inFlag) && !(&inFlag);
  end

endmodule

// File: rtl/dock_flush_dp.sv
`timescale 1ns/1ps
module dock_flush_dp
  import dock_flush_pkg::*;
#(
  parameter int NUM_IN  = 3,
  parameter int NUM_OUT = 2,
  parameter int DATA_W  = 37
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  dock_strobe_t                    strb,
  input  logic [NUM_IN-1:0]               inAckDrop,
  input  logic [NUM_OUT-1:0]              outReqDrop,
  input  logic [NUM_IN-1:0]               inReq,
  input  logic [NUM_IN*(DATA_W+1)-1:0]    inWord,
  output logic [NUM_IN-1:0]               inFlag,
  output logic [NUM_IN-1:0]               ackReg,
  output logic [NUM_IN-1:0]               flushReg,
  output logic [NUM_OUT-1:0]              reqReg,
  output logic [NUM_OUT*(DATA_W+1)-1:0]   outWord
);

  localparam int WORD_W = DATA_W + 1;

  logic [DATA_W-1:0] mix;

  always_comb begin
    mix = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      mix = mix ^ inWord[i*WORD_W +: DATA_W];
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    assign inFlag[i] = inWord[i*WORD_W + DATA_W];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ackReg[i]   <= 1'b1;
        flushReg[i] <= 1'b0;
      end else begin
        if (inAckDrop[i]) ackReg[i] <= 1'b0;
        if (!inReq[i])    flushReg[i] <= 1'b0;
        if (strb.flushAll)
          flushReg[i] <= 1'b1;
        else if (strb.flushSome && !inFlag[i])
          flushReg[i] <= 1'b1;
        if (strb.fire)    ackReg[i] <= 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    localparam logic [DATA_W-1:0] DOCK_IDX = DATA_W'(k);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        reqReg[k]                 <= 1'b0;
        outWord[k*WORD_W +: WORD_W] <= '0;
      end else begin
        if (outReqDrop[k]) reqReg[k] <= 1'b0;
        if (strb.fire) begin
          reqReg[k]                 <= 1'b1;
          outWord[k*WORD_W +: WORD_W] <= {1'b0, mix ^ DOCK_IDX};
        end
      end
    end
  end

endmodule

// File: rtl/dock_flush_top.sv
`timescale 1ns/1ps
module dock_flush_top
  import dock_flush_pkg::*;
#(
  parameter int NUM_IN  = 3,
  parameter int NUM_OUT = 2,
  parameter int DATA_W  = 37
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_IN-1:0]             inReq,
  input  logic [NUM_IN*(DATA_W+1)-1:0]  inWord,
  output logic [NUM_IN-1:0]             inAck,
  output logic [NUM_OUT-1:0]            outReq,
  output logic [NUM_OUT*(DATA_W+1)-1:0] outWord,
  input  logic [NUM_OUT-1:0]            outAck
);

  dock_strobe_t       strb;
  logic [NUM_IN-1:0]  inFlag;
  logic [NUM_IN-1:0]  ackReg;
  logic [NUM_IN-1:0]  flushReg;
  logic [NUM_IN-1:0]  inAckDrop;
  logic [NUM_OUT-1:0] reqReg;
  logic [NUM_OUT-1:0] outReqDrop;

  dock_flush_ctrl #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_ctrl (
    .inReq     (inReq),
    .inFlag    (inFlag),
    .ackReg    (ackReg),
    .flushReg  (flushReg),
    .reqReg    (reqReg),
    .outAck    (outAck),
    .strb      (strb),
    .inAckDrop (inAckDrop),
    .outReqDrop(outReqDrop)
  );

  dock_flush_dp #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .inAckDrop (inAckDrop),
    .outReqDrop(outReqDrop),
    .inReq     (inReq),
    .inWord    (inWord),
    .inFlag    (inFlag),
    .ackReg    (ackReg),
    .flushReg  (flushReg),
    .reqReg    (reqReg),
    .outWord   (outWord)
  );

  assign inAck  = ackReg | flushReg;
  assign outReq = reqReg;

endmodule

// File: rtl/dock_flush_chk.sv
`timescale 1ns/1ps
module dock_flush_chk #(
  parameter int NUM_IN  = 3,
  parameter int NUM_OUT = 2,
  parameter int DATA_W  = 37
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [NUM_IN-1:0]             inReq,
  input logic [NUM_IN*(DATA_W+1)-1:0]  inWord,
  input logic [NUM_IN-1:0]             inAck,
  input logic [NUM_OUT-1:0]            outReq,
  input logic [NUM_OUT*(DATA_W+1)-1:0] outWord,
  input logic [NUM_OUT-1:0]            outAck
);

  localparam int WORD_W = DATA_W + 1;

  logic [NUM_IN-1:0] flags;
  for (genvar i = 0; i < NUM_IN; i++) begin : g_flag
    assign flags[i] = inWord[i*WORD_W + DATA_W];
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (inAck == {NUM_IN{1'b1}}) && (outReq == '0));

  // R3
  drain_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outReq & outAck) != '0 |=> (outReq & $past(outReq & outAck)) == '0);

  // R4
  fire_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outReq & ~$past(outReq)) != '0 |-> (outReq == {NUM_OUT{1'b1}}) && ($past(outReq) == '0));

  // R5
  flush_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&(inReq & ~inAck)) && (&flags) |=> inAck == {NUM_IN{1'b1}});

  // R6
  flush_some_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&(inReq & ~inAck)) && (|flags) && !(&flags) |=> inAck == ~$past(flags));

  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outReq != '0) && (outReq == $past(outReq)) |-> $stable(outWord));

endmodule

bind dock_flush_top dock_flush_chk #(
  .NUM_IN (NUM_IN),
  .NUM_OUT(NUM_OUT),
  .DATA_W (DATA_W)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .inReq  (inReq),
  .inWord (inWord),
  .inAck  (inAck),
  .outReq (outReq),
  .outWord(outWord),
  .outAck (outAck)
);

// File: tb/test_dock_flush_top.sv
`timescale 1ns/1ps
module test_dock_flush_top;

  localparam int NI = 3;
  localparam int NO = 2;
  localparam int W  = 37;
  localparam int WW = W + 1;
  localparam int RUN_CYCLES = 4000;

  logic              clk = 1'b0;
  logic              rstN;
  logic [NI-1:0]     inReq;
  logic [NI*WW-1:0]  inWord;
  logic [NI-1:0]     inAck;
  logic [NO-1:0]     outReq;
  logic [NO*WW-1:0]  outWord;
  logic [NO-1:0]     outAck;

  always #2 clk = ~clk;

  dock_flush_top #(.NUM_IN(NI), .NUM_OUT(NO), .DATA_W(W)) i_dock_flush_top (
    .clk(clk), .rstN(rstN), .inReq(inReq), .inWord(inWord), .inAck(inAck),
    .outReq(outReq), .outWord(outWord), .outAck(outAck)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  bit          mAck[NI];
  bit          mFlush[NI];
  bit          mReq[NO];
  logic [WW-1:0] mWord[NO];
  string       inRule[NI];
  string       outRule[NO];
  string       wordRule[NO];
  int nFire = 0, nAll = 0, nSome = 0, nClr = 0, nDrain = 0, nDrop = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NI; i++) begin mAck[i] = 1; mFlush[i] = 0; inRule[i] = "R1"; end
      for (int k = 0; k < NO; k++) begin mReq[k] = 0; mWord[k] = '0; outRule[k] = "R1"; wordRule[k] = "R1"; end
    end else begin
      bit allFull, allEmpty, allPend, fire;
      int nFlag;
      bit nAck[NI], nFl[NI], nRq[NO];
      logic [W-1:0] x;
      allFull = 1; allEmpty = 1; allPend = 1; nFlag = 0; x = '0;
      for (int i = 0; i < NI; i++) begin
        bit fl, eff;
        fl  = inWord[i*WW + W];
        eff = inReq[i] && !fl;
        if (!(eff && !mAck[i] && !mFlush[i])) allFull = 0;
        if (!(inReq[i] && !mAck[i])) allPend = 0;
        if (fl) nFlag++;
        x = x ^ inWord[i*WW +: W];
        nAck[i] = mAck[i]; nFl[i] = mFlush[i];
        if (!eff && mAck[i]) begin nAck[i] = 0; inRule[i] = "R2"; nDrop++; end
        if (!inReq[i] && mFlush[i]) begin nFl[i] = 0; inRule[i] = "R7"; nClr++; end
      end
      for (int k = 0; k < NO; k++) begin
        if (mReq[k] || outAck[k]) allEmpty = 0;
        nRq[k] = mReq[k];
        if (mReq[k] && outAck[k]) begin nRq[k] = 0; outRule[k] = "R3"; nDrain++; end
      end
      if (allPend && nFlag == NI) begin
        for (int i = 0; i < NI; i++) begin nFl[i] = 1; inRule[i] = "R5"; end
        nAll++;
      end else if (allPend && nFlag > 0) begin
        for (int i = 0; i < NI; i++) begin
          inRule[i] = "R6";
          if (!inWord[i*WW + W]) nFl[i] = 1;
        end
        nSome++;
      end
      fire = allFull && allEmpty;
      if (fire) begin
        nFire++;
        for (int i = 0; i < NI; i++) begin nAck[i] = 1; inRule[i] = "R4"; end
        for (int k = 0; k < NO; k++) begin
          nRq[k] = 1; outRule[k] = "R4"; wordRule[k] = "R4";
          mWord[k] = {1'b0, x ^ W'(k)};
        end
      end else begin
        for (int k = 0; k < NO; k++) begin
          if (nRq[k] == mReq[k]) outRule[k] = "R8";
          wordRule[k] = "R9";
        end
      end
      for (int i = 0; i < NI; i++) begin mAck[i] = nAck[i]; mFlush[i] = nFl[i]; end
      for (int k = 0; k < NO; k++) mReq[k] = nRq[k];
    end
  end

  task automatic compareAll();
    for (int i = 0; i < NI; i++)
      check(inAck[i] == (mAck[i] | mFlush[i]), inRule[i], 64'(inAck[i]), 64'(mAck[i] | mFlush[i]));
    for (int k = 0; k < NO; k++) begin
      check(outReq[k] == mReq[k], outRule[k], 64'(outReq[k]), 64'(mReq[k]));
      if (mReq[k])
        check(outWord[k*WW +: WW] == mWord[k], wordRule[k], 64'(outWord[k*WW +: WW]), 64'(mWord[k]));
    end
  endtask

  logic [31:0] lfsr = 32'h1D2C_3B4A;
  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  int pState[NI];
  bit flushMode;

  task automatic drive();
    bit held;
    held = 0;
    for (int i = 0; i < NI; i++) if (inReq[i] && inWord[i*WW + W]) held = 1;
    for (int i = 0; i < NI; i++) begin
      lfsr = step(lfsr);
      case (pState[i])
        0: if (!inAck[i] && lfsr[1:0] != 2'd0) begin
             logic [63:0] d;
             bit fl;
             fl = (flushMode || held) && lfsr[5];
             lfsr = step(lfsr); d[31:0] = lfsr;
             lfsr = step(lfsr); d[63:32] = lfsr;
             inWord[i*WW +: WW] = {fl, d[W-1:0]};
             inReq[i] = 1'b1;
             pState[i] = 1;
           end
        1: if (inAck[i]) begin inReq[i] = 1'b0; pState[i] = 2; end
        default: if (!inAck[i]) pState[i] = 0;
      endcase
    end
    for (int k = 0; k < NO; k++) begin
      lfsr = step(lfsr);
      if (outReq[k] && !outAck[k] && lfsr[3]) outAck[k] = 1'b1;
      else if (!outReq[k] && outAck[k]) outAck[k] = 1'b0;
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; inReq = '0; outAck = '0;
    for (int i = 0; i < NI; i++) pState[i] = 0;
    repeat (2) @(negedge clk);
    // R1: state right after reset edges
    check(inAck == {NI{1'b1}}, "R1", 64'(inAck), 64'({NI{1'b1}}));
    check(outReq == '0, "R1", 64'(outReq), 64'(0));
    rstN = 1'b1;
  endtask

  initial begin
    inWord = '0; flushMode = 0;
    @(negedge clk);
    doReset();
    for (int c = 0; c < RUN_CYCLES; c++) begin
      @(negedge clk);
      compareAll();
      flushMode = (c >= 1000 && c < 2200);
      if (c == 2600) doReset();
      else drive();
    end
    // coverage of each rule at least once
    check(nFire > 0,  "R4", 64'(nFire), 64'(1));
    check(nAll > 0,   "R5", 64'(nAll), 64'(1));
    check(nSome > 0,  "R6", 64'(nSome), 64'(1));
    check(nClr > 0,   "R7", 64'(nClr), 64'(1));
    check(nDrain > 0, "R3", 64'(nDrain), 64'(1));
    check(nDrop > 0,  "R2", 64'(nDrop), 64'(1));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule